// File: doc/BRIEF.md
# Prescaled Timer, Capture and Compare Channel

This block is one slice of a counter array. A power-of-two prescaler produces a single-cycle advance pulse from the system clock. A free-running 16-bit counter steps on each pulse. One channel either captures the counter value on a selected edge of an external input, or compares the counter against a programmed value. Capture events, compare matches and counter wraps set sticky flags. Software clears a flag by writing 1 to it. The interrupt request is asserted while any flag is set together with its enable bit.

Software reaches the block through a small register port. A write takes effect at the clock edge where `wr_en_i` is high. Reads are combinational on `addr_i`. The register map is:
- 0, CTRL: bit 4 is the count enable and bits 3:0 are the exponent. Reset value 0x10.
- 1, MODE: bits 1:0 select the mode (00 idle, 01 capture, 10 timer). Bits 3:2 select the capture edge. Bit 4 is the event interrupt enable and bit 5 is the overflow interrupt enable.
- 2, CCR: the capture/compare value.
- 3, FLAGS: bit 0 is the event flag and bit 1 is the overflow flag. Writing 1 to a bit clears it.
- 4, COUNT: the counter value, read-only.

Every other address reads 0.

Top module: `pca_channel`

## Requirements
- R1: After reset, CTRL reads 0x10, and COUNT, CCR, MODE and FLAGS read 0. `irq_o` is 0.
- R2: With the count enable at 1 and exponent e, the counter advances once every 2^e clock cycles. Any write to CTRL clears the divider, so N cycles after a CTRL write the counter has advanced by exactly floor(N / 2^e). This holds for e from 0 to 15.
- R3: With the count enable at 0, COUNT holds its value.
- R4: In capture mode, suppose `cap_i` changes before clock edge k. The capture happens at edge k+2: CCR takes the COUNT value seen between edges k+1 and k+2, and the event flag sets at that same edge.
- R5: The edge select field is MODE bits 3:2. Code 01 captures on rising edges, 10 on falling edges, 11 on both, and 00 on neither. An edge that is not selected leaves CCR and the flags unchanged.
- R6: In timer mode (MODE bits 1:0 = 10), the event flag sets at the edge where the counter steps into the CCR value. A counter that is stopped at that value does not set the flag again.
- R7: At the edge where the counter wraps from 0xFFFF to 0x0000, the overflow flag (FLAGS bit 1) sets.
- R8: Flags stay set until software writes 1 to the matching FLAGS bit.
- R9: `irq_o` is 1 exactly when (event flag and MODE bit 4) or (overflow flag and MODE bit 5).
- R10: Values written to MODE (bits 5:0) and CCR read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| cap_i | input | 1 | External capture input, asynchronous |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter wrap is the hardest case to reach, because the counter cannot be loaded. The bench runs the counter at divide-by-one and polls COUNT until it reads 0xFFFF, then checks the flag on the next edge.

Capture timing is also hard to pin down, because the counter keeps moving while the input passes through the synchronizer. The bench samples COUNT in the cycle before the capture edge and compares CCR against that sample. It uses a stopped counter to show that unselected edges are ignored.

// File: rtl/pca_pkg.sv
package pca_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_CAP   = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_RSVD  = 2'b11
  } chan_mode_e;

  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_MODE  = 1;
  localparam int unsigned ADDR_CCR   = 2;
  localparam int unsigned ADDR_FLAGS = 3;
  localparam int unsigned ADDR_COUNT = 4;
endpackage

// File: rtl/pca_prescaler.sv
module pca_prescaler #(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             clr_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask   = ~({DIV_W{1'b1}} << exp_i);
  assign tick_o = en_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (en_i)  div_q <= div_q + 1'b1;
  end

  // R3: gated-off divider is frozen
  p_div_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(div_q));
endmodule

// File: rtl/pca_counter.sv
module pca_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_q + 1'b1;
  assign wrap_o    = tick_i && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt_o;
  end

  p_cnt_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_cnt_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/pca_chan.sv
module pca_chan
  import pca_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  chan_mode_e       mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             cap_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             ccr_we_i,
  input  logic [CNT_W-1:0] ccr_wdata_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic             evt_o
);
  logic [2:0]       sync_q;  // [0],[1] synchronizer, [2] edge history
  logic             rise, fall, cap_hit, match_hit;
  logic [CNT_W-1:0] ccr_q;

  assign rise      = sync_q[1] & ~sync_q[2];
  assign fall      = ~sync_q[1] & sync_q[2];
  assign cap_hit   = (mode_i == MODE_CAP) &&
                     ((edge_sel_i[0] && rise) || (edge_sel_i[1] && fall));
  assign match_hit = (mode_i == MODE_TIMER) && tick_i && (cnt_nxt_i == ccr_q);
  assign evt_o     = cap_hit || match_hit;
  assign ccr_o     = ccr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      ccr_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], cap_i};
      if (cap_hit)       ccr_q <= cnt_i;
      else if (ccr_we_i) ccr_q <= ccr_wdata_i;
    end
  end

  p_cap_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit |=> (ccr_q == $past(cnt_i)));
  p_no_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == 2'b00) |-> !cap_hit);
endmodule

// File: rtl/pca_channel.sv
module pca_channel
  import pca_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned EXP_W  = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              cap_i,
  output logic              irq_o
);
  logic             run_q;
  logic [EXP_W-1:0] exp_q;
  chan_mode_e       mode_q;
  logic [1:0]       edge_q;
  logic             evt_ie_q, ovf_ie_q;
  logic             evt_flag_q, ovf_flag_q;

  logic             ctrl_we, mode_we, ccr_we, flag_we;
  logic             tick, wrap, evt;
  logic [CNT_W-1:0] cnt, cnt_nxt, ccr;

  assign ctrl_we = wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign mode_we = wr_en_i && (addr_i == ADDR_W'(ADDR_MODE));
  assign ccr_we  = wr_en_i && (addr_i == ADDR_W'(ADDR_CCR));
  assign flag_we = wr_en_i && (addr_i == ADDR_W'(ADDR_FLAGS));

  pca_prescaler #(.EXP_W(EXP_W)) u_presc (
    .clk_i, .rst_ni, .en_i(run_q), .exp_i(exp_q), .clr_i(ctrl_we), .tick_o(tick)
  );

  pca_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .wrap_o(wrap)
  );

  pca_chan #(.CNT_W(CNT_W)) u_chan (
    .clk_i, .rst_ni, .mode_i(mode_q), .edge_sel_i(edge_q), .cap_i,
    .tick_i(tick), .cnt_i(cnt), .cnt_nxt_i(cnt_nxt),
    .ccr_we_i(ccr_we), .ccr_wdata_i(wdata_i), .ccr_o(ccr), .evt_o(evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b1;
      exp_q      <= '0;
      mode_q     <= MODE_IDLE;
      edge_q     <= '0;
      evt_ie_q   <= 1'b0;
      ovf_ie_q   <= 1'b0;
      evt_flag_q <= 1'b0;
      ovf_flag_q <= 1'b0;
    end else begin
      if (ctrl_we) begin
        run_q <= wdata_i[EXP_W];
        exp_q <= wdata_i[EXP_W-1:0];
      end
      if (mode_we) begin
        mode_q   <= chan_mode_e'(wdata_i[1:0]);
        edge_q   <= wdata_i[3:2];
        evt_ie_q <= wdata_i[4];
        ovf_ie_q <= wdata_i[5];
      end
      // set beats clear
      evt_flag_q <= evt  || (evt_flag_q && !(flag_we && wdata_i[0]));
      ovf_flag_q <= wrap || (ovf_flag_q && !(flag_we && wdata_i[1]));
    end
  end

  assign irq_o = (evt_flag_q && evt_ie_q) || (ovf_flag_q && ovf_ie_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(ADDR_CTRL):  rdata_o = CNT_W'({run_q, exp_q});
      ADDR_W'(ADDR_MODE):  rdata_o = CNT_W'({ovf_ie_q, evt_ie_q, edge_q, mode_q});
      ADDR_W'(ADDR_CCR):   rdata_o = ccr;
      ADDR_W'(ADDR_FLAGS): rdata_o = CNT_W'({ovf_flag_q, evt_flag_q});
      ADDR_W'(ADDR_COUNT): rdata_o = cnt;
      default:             rdata_o = '0;
    endcase
  end

  p_evt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_flag_q && !(flag_we && wdata_i[0])) |=> evt_flag_q);
  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_q && !(flag_we && wdata_i[1])) |=> ovf_flag_q);
  p_ovf_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_q) |-> (cnt == '0));
  p_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(evt_flag_q) && $past(mode_q) == MODE_TIMER) |-> (cnt == $past(ccr)));
endmodule

// File: tb/pca_channel_tb.sv
`timescale 1ns/1ps
module pca_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cap = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pca_channel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .irq_o(irq)
  );

  typedef struct packed {
    logic        en;
    logic [3:0]  ex;
    logic [15:0] cyc;
    logic [15:0] delta;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 4'd0,  16'd20,  16'd20},
    '{1'b1, 4'd1,  16'd21,  16'd10},
    '{1'b1, 4'd2,  16'd40,  16'd10},
    '{1'b1, 4'd4,  16'd70,  16'd4},
    '{1'b1, 4'd3,  16'd7,   16'd0},
    '{1'b1, 4'd15, 16'd300, 16'd0},
    '{1'b0, 4'd0,  16'd30,  16'd0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, c0, c1, f, target;
    logic prev_f;
    step(2);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0010);
    rd(3'd1, v); chk("R1 mode", v, 16'h0000);
    rd(3'd2, v); chk("R1 ccr", v, 16'h0000);
    rd(3'd3, v); chk("R1 flags", v, 16'h0000);
    rd(3'd4, v); chk("R1 count", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R2/R3 prescaler table
    foreach (VECS[i]) begin
      wr(3'd0, {11'd0, VECS[i].en, VECS[i].ex});
      rd(3'd4, c0);
      step(int'(VECS[i].cyc));
      rd(3'd4, c1);
      chk(VECS[i].en ? "R2 advance" : "R3 frozen", c1 - c0, VECS[i].delta);
    end

    // R10 readback
    wr(3'd1, 16'h002A); rd(3'd1, v); chk("R10 mode", v, 16'h002A);
    wr(3'd2, 16'hBEEF); rd(3'd2, v); chk("R10 ccr", v, 16'hBEEF);

    // R4 rising capture, running counter
    wr(3'd1, 16'h0015);
    wr(3'd0, 16'h0010);
    cap = 1'b1;
    step(1);
    step(1);
    rd(3'd3, f);  chk("R4 no early flag", f, 16'h0000);
    rd(3'd4, c0);
    step(1);
    rd(3'd3, f);  chk("R4 flag", f, 16'h0001);
    rd(3'd2, v);  chk("R4 captured value", v, c0);
    chk("R9 irq event", {15'd0, irq}, 16'd1);
    wr(3'd3, 16'h0001);
    rd(3'd3, f);  chk("R8 clear", f, 16'h0000);
    chk("R9 irq cleared", {15'd0, irq}, 16'd0);

    // R5 ignored falling edge with rising-only select
    wr(3'd0, 16'h0000);
    rd(3'd2, c1);
    cap = 1'b0;
    step(5);
    rd(3'd3, f);  chk("R5 fall ignored flag", f, 16'h0000);
    rd(3'd2, v);  chk("R5 fall ignored ccr", v, c1);

    // R5 both edges
    wr(3'd2, 16'h1234);
    wr(3'd1, 16'h001D);
    rd(3'd4, c0);
    cap = 1'b1;
    step(4);
    rd(3'd2, v);  chk("R5 both rise", v, c0);
    wr(3'd3, 16'h0001);
    wr(3'd2, 16'h5555);
    cap = 1'b0;
    step(4);
    rd(3'd2, v);  chk("R5 both fall", v, c0);
    rd(3'd3, f);  chk("R5 both fall flag", f, 16'h0001);
    wr(3'd3, 16'h0001);

    // R5 falling only: rising ignored, falling taken
    wr(3'd2, 16'h7777);
    wr(3'd1, 16'h0019);
    cap = 1'b1; step(4);
    rd(3'd2, v);  chk("R5 fall-only rise ignored", v, 16'h7777);
    cap = 1'b0; step(4);
    rd(3'd2, v);  chk("R5 fall-only fall", v, c0);

    // R5 none: evt_ie off too, irq must stay 0 (R9)
    wr(3'd3, 16'h0001);
    wr(3'd2, 16'h0abc);
    wr(3'd1, 16'h0001);
    cap = 1'b1; step(4); cap = 1'b0; step(4);
    rd(3'd2, v);  chk("R5 none ccr", v, 16'h0abc);
    rd(3'd3, f);  chk("R5 none flag", f, 16'h0000);

    // R6 timer match
    wr(3'd1, 16'h0012);
    wr(3'd0, 16'h0010);
    rd(3'd4, c0);
    target = c0 + 16'd30;
    wr(3'd2, target);
    prev_f = 1'b0;
    for (int k = 0; k < 100; k++) begin
      step(1);
      rd(3'd4, c1);
      rd(3'd3, f);
      if (c1 == target) begin
        chk("R6 flag before match", {15'd0, prev_f}, 16'd0);
        chk("R6 flag at match", f, 16'h0001);
        chk("R9 irq timer", {15'd0, irq}, 16'd1);
        break;
      end
      prev_f = f[0];
    end
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0001);
    step(10);
    rd(3'd3, f);  chk("R6 no retrigger", f, 16'h0000);

    // R7 overflow
    wr(3'd1, 16'h0020);
    wr(3'd0, 16'h0010);
    for (int k = 0; k < 70000; k++) begin
      rd(3'd4, c1);
      if (c1 == 16'hFFFF) break;
      step(1);
    end
    rd(3'd3, f);  chk("R7 no flag before wrap", f, 16'h0000);
    step(1);
    rd(3'd4, c1); chk("R7 wrapped count", c1, 16'h0000);
    rd(3'd3, f);  chk("R7 overflow flag", f, 16'h0002);
    chk("R9 irq overflow", {15'd0, irq}, 16'd1);
    wr(3'd0, 16'h0000);
    step(5);
    rd(3'd3, f);  chk("R8 sticky", f, 16'h0002);
    wr(3'd3, 16'h0002);
    rd(3'd3, f);  chk("R8 overflow clear", f, 16'h0000);

    finish_run();
  end
endmodule